// File: doc/BRIEF.md
# Banked Far-Call Paging Unit

This block gives a 16-bit CPU access to a larger program store through one 16 KB window whose contents are chosen by an 8-bit page register. Every logical address the core issues can be mapped to a 25-bit flat physical address. Window addresses combine the page and the low 14 address bits above a fixed physical base. Any other address appears on the physical bus unchanged.

The block also carries out the two instructions that move between pages. A far call saves the return PC and the current page on a downward-growing stack, then switches to a new page and target PC. A far return restores both. The decoder hands over one command strobe with the operand address, page byte, indexing postbyte, return PC and SP. The unit then performs the byte-wide stack and pointer transfers on its own memory port. It reports the new PC, SP and page with a one-cycle completion pulse. A debug port can write the page register directly.

Top module: `far_page_unit`

## Requirements
- R1: While and after reset the page register is 0, `busy` and `done` are low, and no memory access is requested.
- R2: A logical address whose two top bits are 2'b10 (0x8000 to 0xBFFF) translates to `{1'b1, 2'b00, page, addr[13:0]}`. That value equals 0x1000000 + (page << 14) + (addr − 0x8000). The translation port follows the page register in the same cycle.
- R3: Every logical address outside that window translates to itself, zero-extended to 25 bits.
- R4: An extended far call (`cmd_op` = 2'b00) writes three bytes: the return PC low byte at SP−1, its high byte at SP−2, and the old page at SP−3, in that order. The call then ends with `page` = `cmd_page`, `pc_out` = `cmd_opnd` and `sp_out` = SP−3.
- R5: A far return (`cmd_op` = 2'b10) reads three bytes: the page at SP, the PC high byte at SP+1 and the PC low byte at SP+2, in that order. The return then ends with those values in `page` and `pc_out`, and with `sp_out` = SP+3.
- R6: An indexed far call (`cmd_op` = 2'b01) is indirect when (`cmd_postbyte` & 0xE3) == 0xE3. It first reads the target high byte at the pointer `cmd_opnd`, then the low byte at pointer+1, then the new page at pointer+2. After that it performs the three pushes of R4.
- R7: An indexed far call whose postbyte does not match the R6 mask makes no reads. It uses `cmd_opnd` as the target and `cmd_page` as the new page, and otherwise behaves as R4.
- R8: Stack and pointer bytes appear on `mem_addr` translated per R2/R3 with the page held at the moment of access. That page is the old page for every transfer of a call.
- R9: `dbg_we` loads `dbg_wdata` into the page register at the next edge when the unit is idle. It is ignored while `busy` is high, and also in the cycle a command is accepted.
- R10: While `busy` is high, new commands are ignored. A command with `cmd_op` = 2'b11 is ignored in any state.
- R11: `busy` is high from the edge that accepts a command until the edge of the last memory transfer. `done` is a one-cycle pulse raised at that edge. `mem_req` is only high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe from the decoder |
| cmd_op | input | 2 | 00 extended call, 01 indexed call, 10 return, 11 none |
| cmd_postbyte | input | 8 | Indexing postbyte of an indexed call |
| cmd_opnd | input | 16 | Target address or indirect pointer |
| cmd_page | input | 8 | Page byte from the instruction stream |
| cmd_ret_pc | input | 16 | Return PC to save on a call |
| cmd_sp | input | 16 | Stack pointer at the start of the command |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | PC to load, valid with `done` |
| sp_out | output | 16 | SP to load, valid with `done` |
| page | output | 8 | Current page register |
| dbg_we | input | 1 | Debug write strobe for the page register |
| dbg_wdata | input | 8 | Debug write data |
| xl_laddr | input | 16 | Logical address to translate |
| xl_paddr | output | 25 | Translated physical address |
| mem_req | output | 1 | Memory byte transfer this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 25 | Physical byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, sampled at the edge ending the request cycle |

## Verification
The hardest situation to reach is a stack or pointer transfer that itself lands in the banked window. In that case the physical address depends on the page value that the same sequence is about to replace. The bench places SP and an indirect pointer inside 0x8000–0xBFFF just after a call has left a non-zero page. It then predicts every transfer address with the page that was current before the call. A second awkward case is a command and a debug write arriving in the middle of a sequence. The bench raises both while `busy` is high and relies on the scoreboard to flag any extra transfer or page change.

// File: rtl/fpu_pkg.sv
package fpu_pkg;
    parameter int LW    = 16;   // logical address width
    parameter int PW    = 8;    // page register width
    parameter int OFS_W = 14;   // window offset width (16 KB)
    parameter int PHW   = 25;   // physical address width
    localparam int GAP_W = PHW - 1 - PW - OFS_W;
    localparam logic [7:0] IND_MASK = 8'hE3;

    typedef enum logic [1:0] {
        OP_CALL_EXT = 2'b00,
        OP_CALL_IDX = 2'b01,
        OP_RETURN   = 2'b10,
        OP_NONE     = 2'b11
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_PTR_HI, S_PTR_LO, S_PTR_PG,
        S_PUSH_LO, S_PUSH_HI, S_PUSH_PG,
        S_POP_PG, S_POP_HI, S_POP_LO
    } st_e;

    typedef struct packed {
        logic          req;
        logic          we;
        logic [LW-1:0] laddr;
        logic [7:0]    wdata;
    } bus_t;

    function automatic logic [PHW-1:0] xlate(input logic [LW-1:0] a,
                                             input logic [PW-1:0] pg);
        if (a[LW-1 -: 2] == 2'b10)
            return {1'b1, {GAP_W{1'b0}}, pg, a[OFS_W-1:0]};
        else
            return {{(PHW-LW){1'b0}}, a};
    endfunction
endpackage

// File: rtl/fpu_xlate.sv
module fpu_xlate
    import fpu_pkg::*;
(
    input  logic [LW-1:0]  laddr,
    input  logic [PW-1:0]  pg,
    output logic [PHW-1:0] paddr
);
    always_comb paddr = xlate(laddr, pg);
endmodule

// File: rtl/fpu_page_reg.sv
module fpu_page_reg
    import fpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [PW-1:0] ld_val,
    input  logic          dbg_we,
    input  logic [PW-1:0] dbg_wdata,
    input  logic          blocked,
    output logic [PW-1:0] page_q
);
    always_ff @(posedge clk) begin
        if (rst)
            page_q <= '0;
        else if (ld)
            page_q <= ld_val;
        else if (dbg_we && !blocked)
            page_q <= dbg_wdata;
    end
endmodule

// File: rtl/fpu_seq.sv
module fpu_seq
    import fpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [7:0]    cmd_postbyte,
    input  logic [LW-1:0] cmd_opnd,
    input  logic [PW-1:0] cmd_page,
    input  logic [LW-1:0] cmd_ret_pc,
    input  logic [LW-1:0] cmd_sp,
    input  logic [7:0]    mem_rdata,
    input  logic [PW-1:0] page_cur,
    output bus_t          bus,
    output logic          busy,
    output logic          accept,
    output logic          pg_ld,
    output logic [PW-1:0] pg_val,
    output logic [LW-1:0] pc_out,
    output logic [LW-1:0] sp_out,
    output logic          done
);
    st_e           st;
    logic [LW-1:0] tgt, ptr, sp_b, rpc;
    logic [PW-1:0] tpg, pop_pg;
    logic [7:0]    pop_hi;
    op_e           op;

    assign op     = op_e'(cmd_op);
    assign busy   = (st != S_IDLE);
    assign accept = (st == S_IDLE) && cmd_valid && (op != OP_NONE);
    assign pg_ld  = (st == S_PUSH_PG) || (st == S_POP_LO);
    assign pg_val = (st == S_PUSH_PG) ? tpg : pop_pg;

    always_comb begin
        bus = '0;
        unique case (st)
            S_PTR_HI:  bus = '{req: 1'b1, we: 1'b0, laddr: ptr,        wdata: 8'h00};
            S_PTR_LO:  bus = '{req: 1'b1, we: 1'b0, laddr: ptr + 16'd1, wdata: 8'h00};
            S_PTR_PG:  bus = '{req: 1'b1, we: 1'b0, laddr: ptr + 16'd2, wdata: 8'h00};
            S_PUSH_LO: bus = '{req: 1'b1, we: 1'b1, laddr: sp_b - 16'd1, wdata: rpc[7:0]};
            S_PUSH_HI: bus = '{req: 1'b1, we: 1'b1, laddr: sp_b - 16'd2, wdata: rpc[15:8]};
            S_PUSH_PG: bus = '{req: 1'b1, we: 1'b1, laddr: sp_b - 16'd3, wdata: page_cur};
            S_POP_PG:  bus = '{req: 1'b1, we: 1'b0, laddr: sp_b,        wdata: 8'h00};
            S_POP_HI:  bus = '{req: 1'b1, we: 1'b0, laddr: sp_b + 16'd1, wdata: 8'h00};
            S_POP_LO:  bus = '{req: 1'b1, we: 1'b0, laddr: sp_b + 16'd2, wdata: 8'h00};
            default:   bus = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            done   <= 1'b0;
            pc_out <= '0;
            sp_out <= '0;
            tgt    <= '0;
            ptr    <= '0;
            sp_b   <= '0;
            rpc    <= '0;
            tpg    <= '0;
            pop_pg <= '0;
            pop_hi <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                S_IDLE: if (accept) begin
                    sp_b <= cmd_sp;
                    rpc  <= cmd_ret_pc;
                    tgt  <= cmd_opnd;
                    ptr  <= cmd_opnd;
                    tpg  <= cmd_page;
                    if (op == OP_RETURN)
                        st <= S_POP_PG;
                    else if (op == OP_CALL_IDX && (cmd_postbyte & IND_MASK) == IND_MASK)
                        st <= S_PTR_HI;
                    else
                        st <= S_PUSH_LO;
                end
                S_PTR_HI:  begin tgt[15:8] <= mem_rdata; st <= S_PTR_LO;  end
                S_PTR_LO:  begin tgt[7:0]  <= mem_rdata; st <= S_PTR_PG;  end
                S_PTR_PG:  begin tpg       <= mem_rdata; st <= S_PUSH_LO; end
                S_PUSH_LO: st <= S_PUSH_HI;
                S_PUSH_HI: st <= S_PUSH_PG;
                S_PUSH_PG: begin
                    pc_out <= tgt;
                    sp_out <= sp_b - 16'd3;
                    done   <= 1'b1;
                    st     <= S_IDLE;
                end
                S_POP_PG:  begin pop_pg <= mem_rdata; st <= S_POP_HI; end
                S_POP_HI:  begin pop_hi <= mem_rdata; st <= S_POP_LO; end
                S_POP_LO:  begin
                    pc_out <= {pop_hi, mem_rdata};
                    sp_out <= sp_b + 16'd3;
                    done   <= 1'b1;
                    st     <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/far_page_unit.sv
module far_page_unit
    import fpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [7:0]       cmd_postbyte,
    input  logic [LW-1:0]    cmd_opnd,
    input  logic [PW-1:0]    cmd_page,
    input  logic [LW-1:0]    cmd_ret_pc,
    input  logic [LW-1:0]    cmd_sp,
    output logic             busy,
    output logic             done,
    output logic [LW-1:0]    pc_out,
    output logic [LW-1:0]    sp_out,
    output logic [PW-1:0]    page,
    input  logic             dbg_we,
    input  logic [PW-1:0]    dbg_wdata,
    input  logic [LW-1:0]    xl_laddr,
    output logic [PHW-1:0]   xl_paddr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PHW-1:0]   mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata
);
    bus_t          bus;
    logic          pg_ld, accept;
    logic [PW-1:0] pg_val;

    fpu_seq u_seq (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_postbyte(cmd_postbyte),
        .cmd_opnd(cmd_opnd), .cmd_page(cmd_page), .cmd_ret_pc(cmd_ret_pc),
        .cmd_sp(cmd_sp), .mem_rdata(mem_rdata), .page_cur(page),
        .bus(bus), .busy(busy), .accept(accept), .pg_ld(pg_ld), .pg_val(pg_val),
        .pc_out(pc_out), .sp_out(sp_out), .done(done)
    );

    fpu_page_reg u_page (
        .clk(clk), .rst(rst), .ld(pg_ld), .ld_val(pg_val),
        .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .blocked(busy || accept),
        .page_q(page)
    );

    fpu_xlate u_xl_port (.laddr(xl_laddr),  .pg(page), .paddr(xl_paddr));
    fpu_xlate u_xl_mem  (.laddr(bus.laddr), .pg(page), .paddr(mem_addr));

    assign mem_req   = bus.req;
    assign mem_we    = bus.we;
    assign mem_wdata = bus.wdata;
endmodule

// File: rtl/fpu_checker.sv
module fpu_checker
    import fpu_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           busy,
    input logic           done,
    input logic [PW-1:0]  page,
    input logic           dbg_we,
    input logic           cmd_valid,
    input logic [LW-1:0]  xl_laddr,
    input logic [PHW-1:0] xl_paddr,
    input logic           mem_req
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (page == '0 && !busy && !done && !mem_req));

    a_r2_window_map: assert property (@(posedge clk) disable iff (rst)
        (xl_laddr[LW-1 -: 2] == 2'b10) |->
        (xl_paddr[PHW-1] && xl_paddr[PHW-2 -: GAP_W] == '0 &&
         xl_paddr[OFS_W +: PW] == page && xl_paddr[OFS_W-1:0] == xl_laddr[OFS_W-1:0]));

    a_r3_passthrough: assert property (@(posedge clk) disable iff (rst)
        (xl_laddr[LW-1 -: 2] != 2'b10) |-> (xl_paddr == {{(PHW-LW){1'b0}}, xl_laddr}));

    a_r9_page_change_cause: assert property (@(posedge clk) disable iff (rst)
        !$stable(page) |-> (done || $past(dbg_we && !busy && !cmd_valid) || $past(dbg_we && !busy)));

    a_r11_req_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));
endmodule

bind far_page_unit fpu_checker i_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .page(page),
    .dbg_we(dbg_we), .cmd_valid(cmd_valid), .xl_laddr(xl_laddr),
    .xl_paddr(xl_paddr), .mem_req(mem_req)
);

// File: tb/test_far_page_unit.sv
module test_far_page_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b11;
    logic [7:0]  cmd_postbyte = 8'h00;
    logic [15:0] cmd_opnd = '0, cmd_ret_pc = '0, cmd_sp = '0;
    logic [7:0]  cmd_page = '0;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] pc_out, sp_out;
    logic [7:0]  page, mem_wdata, mem_rdata;
    logic        dbg_we = 1'b0;
    logic [7:0]  dbg_wdata = '0;
    logic [15:0] xl_laddr = '0;
    logic [24:0] xl_paddr, mem_addr;

    int checks = 0;
    int errors = 0;
    logic [7:0] mpage = 8'h00;

    typedef struct { logic we; logic [24:0] addr; logic [7:0] data; string tag; } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    far_page_unit i_far_page_unit (.*);

    function automatic logic [24:0] px(input logic [15:0] a, input logic [7:0] pg);
        if (a >= 16'h8000 && a <= 16'hBFFF)
            return 25'h1000000 + (25'(pg) << 14) + 25'(a - 16'h8000);
        return 25'(a);
    endfunction

    function automatic logic [7:0] fmem(input logic [24:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ {7'b0, a[24]} ^ 8'h5A;
    endfunction

    assign mem_rdata = mem_req ? fmem(mem_addr) : 8'h00;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_exp(input logic we, input logic [24:0] a, input logic [7:0] d, input string tag);
        item_t it;
        it.we = we; it.addr = a; it.data = d; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // monitor: compare each transfer against the scoreboard
    always @(negedge clk) begin
        if (!rst && mem_req) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected transfer", {7'b0, mem_addr}, 32'h0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(mem_we == it.we && mem_addr == it.addr && (!it.we || mem_wdata == it.data),
                    it.tag, {mem_we, mem_addr[22:0], mem_wdata}, {it.we, it.addr[22:0], it.data});
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic [7:0] post, input logic [15:0] opnd,
                         input logic [7:0] pg, input logic [15:0] ret, input logic [15:0] sp);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_postbyte = post; cmd_opnd = opnd;
        cmd_page = pg; cmd_ret_pc = ret; cmd_sp = sp;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b11;
    endtask

    task automatic wait_done(input string tag);
        logic seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
        chk(seen, {tag, " R11 done seen"}, {31'b0, seen}, 32'h1);
    endtask

    task automatic do_call(input logic [1:0] op, input logic [7:0] post, input logic [15:0] opnd,
                           input logic [7:0] pg, input logic [15:0] ret, input logic [15:0] sp,
                           input string tag);
        logic [15:0] tgt;
        logic [7:0]  npg;
        logic        ind;
        ind = (op == 2'b01) && ((post & 8'hE3) == 8'hE3);
        tgt = opnd; npg = pg;
        if (ind) begin
            tgt = {fmem(px(opnd, mpage)), fmem(px(opnd + 16'd1, mpage))};
            npg = fmem(px(opnd + 16'd2, mpage));
            push_exp(1'b0, px(opnd, mpage), 8'h00, {tag, " R6 ptr hi"});
            push_exp(1'b0, px(opnd + 16'd1, mpage), 8'h00, {tag, " R6 ptr lo"});
            push_exp(1'b0, px(opnd + 16'd2, mpage), 8'h00, {tag, " R6 ptr page"});
        end
        push_exp(1'b1, px(sp - 16'd1, mpage), ret[7:0],  {tag, " R4 push lo"});
        push_exp(1'b1, px(sp - 16'd2, mpage), ret[15:8], {tag, " R4 push hi"});
        push_exp(1'b1, px(sp - 16'd3, mpage), mpage,     {tag, " R4 push page"});
        issue(op, post, opnd, pg, ret, sp);
        wait_done(tag);
        chk(pc_out == tgt, {tag, " R4 pc_out"}, {16'b0, pc_out}, {16'b0, tgt});
        chk(sp_out == sp - 16'd3, {tag, " R4 sp_out"}, {16'b0, sp_out}, {16'b0, sp - 16'd3});
        chk(page == npg, {tag, " R4 page"}, {24'b0, page}, {24'b0, npg});
        chk(exp_q.size() == 0, {tag, " R7 transfer count"}, exp_q.size(), 0);
        mpage = npg;
        @(negedge clk);
        chk(!done && !busy, {tag, " R11 done pulse"}, {30'b0, done, busy}, 32'h0);
    endtask

    task automatic do_return(input logic [15:0] sp, input string tag);
        logic [7:0]  npg;
        logic [15:0] npc;
        npg = fmem(px(sp, mpage));
        npc = {fmem(px(sp + 16'd1, mpage)), fmem(px(sp + 16'd2, mpage))};
        push_exp(1'b0, px(sp, mpage), 8'h00, {tag, " R5 pop page"});
        push_exp(1'b0, px(sp + 16'd1, mpage), 8'h00, {tag, " R5 pop hi"});
        push_exp(1'b0, px(sp + 16'd2, mpage), 8'h00, {tag, " R5 pop lo"});
        issue(2'b10, 8'h00, 16'h0, 8'h00, 16'h0, sp);
        wait_done(tag);
        chk(pc_out == npc, {tag, " R5 pc_out"}, {16'b0, pc_out}, {16'b0, npc});
        chk(sp_out == sp + 16'd3, {tag, " R5 sp_out"}, {16'b0, sp_out}, {16'b0, sp + 16'd3});
        chk(page == npg, {tag, " R5 page"}, {24'b0, page}, {24'b0, npg});
        chk(exp_q.size() == 0, {tag, " R5 transfer count"}, exp_q.size(), 0);
        mpage = npg;
        @(negedge clk);
    endtask

    task automatic chk_xl(input logic [15:0] a, input string tag);
        @(negedge clk);
        xl_laddr = a;
        #1;
        chk(xl_paddr == px(a, mpage), tag, {7'b0, xl_paddr}, {7'b0, px(a, mpage)});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        chk(page == 8'h00 && !busy && !done && !mem_req, "R1 reset state",
            {21'b0, page, busy, done, mem_req}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(page == 8'h00 && !busy, "R1 after reset", {23'b0, page, busy}, 32'h0);

        chk_xl(16'h8000, "R2 window base page 0");
        chk_xl(16'h7FFF, "R3 below window");
        chk_xl(16'hC000, "R3 above window");

        do_call(2'b00, 8'h00, 16'h9000, 8'h05, 16'h1234, 16'h2000, "ext call");
        chk_xl(16'hBFFF, "R2 window top page 5");
        chk_xl(16'h8123, "R2 window mid page 5");

        do_return(16'h1FFD, "return");

        do_call(2'b01, 8'hE3, 16'h3000, 8'h11, 16'h4567, 16'h2400, "R6 indirect E3");
        do_call(2'b01, 8'hE7, 16'h8100, 8'h22, 16'hABCD, 16'h2400, "R8 indirect ptr in window");
        do_call(2'b01, 8'hE2, 16'h8800, 8'h33, 16'h0101, 16'h2400, "R7 indexed E2");
        do_call(2'b01, 8'h63, 16'h4444, 8'h09, 16'h0202, 16'h2400, "R7 indexed 63");
        do_call(2'b00, 8'h00, 16'h9ABC, 8'h40, 16'h7788, 16'h8010, "R8 stack in window");
        do_return(16'h8001, "R8 return in window");

        // R10/R9: command and debug write while busy are ignored
        begin
            logic [7:0] old;
            old = mpage;
            push_exp(1'b1, px(16'h2FFF, mpage), 8'h66, "R10 push lo");
            push_exp(1'b1, px(16'h2FFE, mpage), 8'h55, "R10 push hi");
            push_exp(1'b1, px(16'h2FFD, mpage), old,   "R10 push page");
            issue(2'b00, 8'h00, 16'h1357, 8'h0C, 16'h5566, 16'h3000);
            chk(busy, "R11 busy while sequencing", {31'b0, busy}, 32'h1);
            cmd_valid = 1'b1; cmd_op = 2'b10; cmd_sp = 16'h0100;
            dbg_we = 1'b1; dbg_wdata = 8'hAA;
            @(negedge clk);
            cmd_valid = 1'b0; cmd_op = 2'b11; dbg_we = 1'b0;
            chk(page == old, "R9 debug write ignored while busy", {24'b0, page}, {24'b0, old});
            wait_done("R10 busy");
            chk(pc_out == 16'h1357 && page == 8'h0C, "R10 command while busy ignored",
                {8'b0, pc_out, page}, {8'b0, 16'h1357, 8'h0C});
            mpage = 8'h0C;
            repeat (4) @(negedge clk);
            chk(exp_q.size() == 0 && !busy, "R10 no extra transfers", exp_q.size(), 0);
        end

        // R9: debug write when idle
        dbg_we = 1'b1; dbg_wdata = 8'h77;
        @(negedge clk);
        dbg_we = 1'b0;
        chk(page == 8'h77, "R9 debug write idle", {24'b0, page}, 32'h77);
        mpage = 8'h77;
        chk_xl(16'hA000, "R2 window after debug write");

        // R10: reserved op ignored
        cmd_valid = 1'b1; cmd_op = 2'b11; cmd_sp = 16'h1000;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && page == 8'h77, "R10 reserved op ignored",
            {22'b0, busy, done, page}, 32'h77);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule